// File: doc/BRIEF.md
# Converter Power-Up Sequencer

This block drives the enable lines of an analog-to-digital converter from fully off to usable, in a fixed order. After a start request it turns on the converter clock. A short lead time later it powers the bandgap and reference. It then waits a long settling time measured in microseconds, powers the converter core, and waits a short settling time before it raises a ready flag. Each wait is converted from microseconds to clock cycles at elaboration time from the clock frequency parameter, and the result is rounded up so that no wait is ever shorter than asked.

Conversion requests pass through a gate. A request made while ready is high is accepted. A request made earlier is refused, and it sets a sticky error bit that only reset clears. The analog circuits and the conversion itself are outside this block.

Top module: `adc_pwrup_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives `adc_clk_en`, `ref_pwr_en`, `core_pwr_en`, `ready`, `conv_accept` and `early_req` to 0 from that edge on, and returns the sequencer to idle.
- R2: In idle, all enables stay 0 until `start` is sampled high. The edge that samples it raises `adc_clk_en`. `ref_pwr_en` then rises exactly `CLK_LEAD_CYCLES` cycles later.
- R3: `core_pwr_en` rises exactly ceil(`REF_WAIT_US` * `CLK_FREQ_HZ` / 1e6) cycles after `ref_pwr_en` rises. Elaboration rejects a `REF_WAIT_US` below 5000, a zero `CORE_WAIT_US`, a zero `CLK_FREQ_HZ` and a zero `CLK_LEAD_CYCLES`.
- R4: `ready` rises exactly ceil(`CORE_WAIT_US` * `CLK_FREQ_HZ` / 1e6) cycles after `core_pwr_en` rises.
- R5: The outputs only ever turn on in order. `ref_pwr_en` implies `adc_clk_en`, `core_pwr_en` implies `ref_pwr_en`, and `ready` implies `core_pwr_en`.
- R6: Once an enable or `ready` is high, it stays high until reset. A `start` pulse after leaving idle has no effect on the timing or the outputs.
- R7: When `conv_req` is high at an edge while `ready` is low, `early_req` is 1 from that edge and stays 1 until reset, and `conv_accept` stays 0.
- R8: When `conv_req` is high while `ready` is high, `conv_accept` is 1 in the following cycle (with the default `ACCEPT_REG`=1; with 0 it is 1 in the same cycle). It is 1 for each cycle the request is held, and `early_req` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin the power-up sequence |
| conv_req | input | 1 | Request to start a conversion |
| adc_clk_en | output | 1 | Converter clock enable, the first stage |
| ref_pwr_en | output | 1 | Bandgap and reference power enable, the second stage |
| core_pwr_en | output | 1 | Converter core power enable, the third stage |
| ready | output | 1 | First conversion permitted |
| conv_accept | output | 1 | Conversion request accepted |
| early_req | output | 1 | Sticky flag: a request arrived before ready |

## Verification
The assertions assume that `start`, `conv_req` and `rst` are synchronous to `clk`, and that reset is held high from time zero through at least one rising edge. The stage-length checks also assume that each power-up runs once per reset, because their cycle counters clear only on reset. The stimulus therefore holds reset from the first instant, drives every input at falling edges, and asserts reset again before each new power-up.

// File: rtl/adc_pwrup_pkg.sv
`timescale 1ns/1ps
package adc_pwrup_pkg;

   // Sequencer stages, ordered so that a later stage keeps every earlier enable
   typedef enum logic [2:0] {
      PS_OFF   = 3'd0,
      PS_CLK   = 3'd1,
      PS_REF   = 3'd2,
      PS_CORE  = 3'd3,
      PS_READY = 3'd4
   } pwr_state_e;

   localparam int unsigned MIN_REF_WAIT_US = 5000;

   // Microseconds to clock cycles, rounded up
   function automatic longint unsigned us_to_cycles(input longint unsigned freq_hz,
                                                    input longint unsigned dur_us);
      return (freq_hz * dur_us + 64'd999_999) / 64'd1_000_000;
   endfunction

   function automatic int unsigned max3(input int unsigned a,
                                        input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/adc_pwrup_timer.sv
`timescale 1ns/1ps
module adc_pwrup_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_pwrup_fsm.sv
`timescale 1ns/1ps
module adc_pwrup_fsm
   import adc_pwrup_pkg::*;
#(
   parameter int unsigned      CNT_W     = 8,
   parameter logic [CNT_W-1:0] LEAD_LOAD = '0,
   parameter logic [CNT_W-1:0] REF_LOAD  = '0,
   parameter logic [CNT_W-1:0] CORE_LOAD = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             expired,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output logic             clk_en,
   output logic             ref_en,
   output logic             core_en,
   output logic             rdy
);

   pwr_state_e st_q, st_d;

   always_ff @(posedge clk) begin
      if (rst) st_q <= PS_OFF;
      else     st_q <= st_d;
   end

   // Each transition into a timed stage loads the stage length minus one
   always_comb begin
      st_d     = st_q;
      load     = 1'b0;
      load_val = '0;
      case (st_q)
         PS_OFF: begin
            if (start) begin
               st_d     = PS_CLK;
               load     = 1'b1;
               load_val = LEAD_LOAD;
            end
         end
         PS_CLK: begin
            if (expired) begin
               st_d     = PS_REF;
               load     = 1'b1;
               load_val = REF_LOAD;
            end
         end
         PS_REF: begin
            if (expired) begin
               st_d     = PS_CORE;
               load     = 1'b1;
               load_val = CORE_LOAD;
            end
         end
         PS_CORE: begin
            if (expired) st_d = PS_READY;
         end
         PS_READY: st_d = PS_READY;
         default:  st_d = PS_OFF;
      endcase
   end

   assign clk_en  = (st_q == PS_CLK) || (st_q == PS_REF) ||
                    (st_q == PS_CORE) || (st_q == PS_READY);
   assign ref_en  = (st_q == PS_REF) || (st_q == PS_CORE) || (st_q == PS_READY);
   assign core_en = (st_q == PS_CORE) || (st_q == PS_READY);
   assign rdy     = (st_q == PS_READY);

endmodule

// File: rtl/adc_pwrup_convgate.sv
`timescale 1ns/1ps
module adc_pwrup_convgate #(
   parameter bit ACCEPT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic conv_req,
   input  logic rdy,
   output logic conv_accept,
   output logic early_req
);

   always_ff @(posedge clk) begin
      if (rst)                  early_req <= 1'b0;
      else if (conv_req && !rdy) early_req <= 1'b1;
   end

   generate
      if (ACCEPT_REG) begin : g_accept_reg
         logic acc_q;
         always_ff @(posedge clk) begin
            if (rst) acc_q <= 1'b0;
            else     acc_q <= conv_req && rdy;
         end
         assign conv_accept = acc_q;
      end else begin : g_accept_comb
         assign conv_accept = conv_req && rdy;
      end
   endgenerate

endmodule

// File: rtl/adc_pwrup_seq.sv
`timescale 1ns/1ps
module adc_pwrup_seq
   import adc_pwrup_pkg::*;
#(
   parameter int unsigned CLK_FREQ_HZ     = 100_000_000,
   parameter int unsigned REF_WAIT_US     = 8000,
   parameter int unsigned CORE_WAIT_US    = 20,
   parameter int unsigned CLK_LEAD_CYCLES = 4,
   parameter bit          ACCEPT_REG      = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic conv_req,
   output logic adc_clk_en,
   output logic ref_pwr_en,
   output logic core_pwr_en,
   output logic ready,
   output logic conv_accept,
   output logic early_req
);

   localparam int unsigned REF_CYC  = 32'(us_to_cycles(CLK_FREQ_HZ, REF_WAIT_US));
   localparam int unsigned CORE_CYC = 32'(us_to_cycles(CLK_FREQ_HZ, CORE_WAIT_US));
   localparam int unsigned MAX_CYC  = max3(CLK_LEAD_CYCLES, REF_CYC, CORE_CYC);
   localparam int unsigned CNT_W    = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
   localparam logic [CNT_W-1:0] LEAD_LOAD = CNT_W'(CLK_LEAD_CYCLES - 1);
   localparam logic [CNT_W-1:0] REF_LOAD  = CNT_W'(REF_CYC - 1);
   localparam logic [CNT_W-1:0] CORE_LOAD = CNT_W'(CORE_CYC - 1);

   generate
      if (CLK_FREQ_HZ == 0) begin : g_bad_freq
         $error("adc_pwrup_seq: CLK_FREQ_HZ must be non-zero");
      end
      if (REF_WAIT_US < MIN_REF_WAIT_US) begin : g_bad_ref
         $error("adc_pwrup_seq: REF_WAIT_US below the minimum settling time");
      end
      if (CORE_WAIT_US == 0) begin : g_bad_core
         $error("adc_pwrup_seq: CORE_WAIT_US must be non-zero");
      end
      if (CLK_LEAD_CYCLES == 0) begin : g_bad_lead
         $error("adc_pwrup_seq: CLK_LEAD_CYCLES must be non-zero");
      end
   endgenerate

   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;
   logic             rdy_int;

   adc_pwrup_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   adc_pwrup_fsm #(
      .CNT_W     (CNT_W),
      .LEAD_LOAD (LEAD_LOAD),
      .REF_LOAD  (REF_LOAD),
      .CORE_LOAD (CORE_LOAD)
   ) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .expired  (tmr_expired),
      .load     (tmr_load),
      .load_val (tmr_val),
      .clk_en   (adc_clk_en),
      .ref_en   (ref_pwr_en),
      .core_en  (core_pwr_en),
      .rdy      (rdy_int)
   );

   adc_pwrup_convgate #(.ACCEPT_REG(ACCEPT_REG)) u_gate (
      .clk         (clk),
      .rst         (rst),
      .conv_req    (conv_req),
      .rdy         (rdy_int),
      .conv_accept (conv_accept),
      .early_req   (early_req)
   );

   assign ready = rdy_int;

endmodule

// File: rtl/adc_pwrup_seq_chk.sv
`timescale 1ns/1ps
module adc_pwrup_seq_chk #(
   parameter int unsigned LEAD_CYC   = 1,
   parameter int unsigned REF_CYC    = 1,
   parameter int unsigned CORE_CYC   = 1,
   parameter bit          ACCEPT_REG = 1'b1
) (
   input logic clk,
   input logic rst,
   input logic start,
   input logic conv_req,
   input logic adc_clk_en,
   input logic ref_pwr_en,
   input logic core_pwr_en,
   input logic ready,
   input logic conv_accept,
   input logic early_req
);

   int unsigned lead_run, ref_run, core_run;
   logic        rst_seen;

   always_ff @(posedge clk) begin
      if (rst) begin
         lead_run <= 0;
         ref_run  <= 0;
         core_run <= 0;
      end else begin
         if (adc_clk_en && !ref_pwr_en)  lead_run <= lead_run + 1;
         if (ref_pwr_en && !core_pwr_en) ref_run  <= ref_run + 1;
         if (core_pwr_en && !ready)      core_run <= core_run + 1;
      end
   end

   always_ff @(posedge clk) begin
      rst_seen <= rst;
      if (rst_seen == 1'b1) begin
         // R1
         reset_clears_chk: assert (!adc_clk_en && !ref_pwr_en && !core_pwr_en &&
                                   !ready && !conv_accept && !early_req);
      end
   end

   // R2
   clk_first_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(adc_clk_en) |-> (!ref_pwr_en && $past(start)));
   // R2
   lead_len_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ref_pwr_en) |-> (lead_run == LEAD_CYC));
   // R3
   ref_wait_len_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(core_pwr_en) |-> (ref_run == REF_CYC));
   // R4
   core_wait_len_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ready) |-> (core_run == CORE_CYC));
   // R5
   ref_needs_clk_chk: assert property (@(posedge clk) disable iff (rst)
      ref_pwr_en |-> adc_clk_en);
   // R5
   core_needs_ref_chk: assert property (@(posedge clk) disable iff (rst)
      core_pwr_en |-> ref_pwr_en);
   // R5
   ready_needs_core_chk: assert property (@(posedge clk) disable iff (rst)
      ready |-> core_pwr_en);
   // R6
   clk_hold_chk: assert property (@(posedge clk) disable iff (rst)
      adc_clk_en |=> adc_clk_en);
   // R6
   ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ready |=> ready);
   // R7
   early_set_chk: assert property (@(posedge clk) disable iff (rst)
      (conv_req && !ready) |=> early_req);
   // R7
   early_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      early_req |=> early_req);
   // R8
   accept_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
      conv_accept |-> ready);

   generate
      if (ACCEPT_REG) begin : g_reg_chk
         // R8
         accept_next_chk: assert property (@(posedge clk) disable iff (rst)
            (conv_req && ready) |=> conv_accept);
      end else begin : g_comb_chk
         // R8
         accept_same_chk: assert property (@(posedge clk) disable iff (rst)
            (conv_req && ready) |-> conv_accept);
      end
   endgenerate

endmodule

bind adc_pwrup_seq adc_pwrup_seq_chk #(
   .LEAD_CYC   (CLK_LEAD_CYCLES),
   .REF_CYC    (REF_CYC),
   .CORE_CYC   (CORE_CYC),
   .ACCEPT_REG (ACCEPT_REG)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .start       (start),
   .conv_req    (conv_req),
   .adc_clk_en  (adc_clk_en),
   .ref_pwr_en  (ref_pwr_en),
   .core_pwr_en (core_pwr_en),
   .ready       (ready),
   .conv_accept (conv_accept),
   .early_req   (early_req)
);

// File: tb/tb_adc_pwrup_seq.sv
`timescale 1ns/1ps
module tb_adc_pwrup_seq;

   // 1,234,567 Hz: 8000 us -> 9876.536 -> 9877 cycles; 20 us -> 24.69 -> 25 cycles
   localparam int unsigned T_LEAD = 2;
   localparam int unsigned T_REF  = 9877;
   localparam int unsigned T_CORE = 25;
   localparam int unsigned C_REF  = T_LEAD + 1;
   localparam int unsigned C_CORE = C_REF + T_REF;
   localparam int unsigned C_RDY  = C_CORE + T_CORE;
   localparam int unsigned C_LAST = C_RDY + 45;
   localparam int NV = 9;

   // Probe cycle (falling edges after the start sample) and expected {clk,ref,core,ready}
   localparam int unsigned VC [NV] = '{1, 2, C_REF - 1, C_REF, C_CORE - 1, C_CORE,
                                       C_RDY - 1, C_RDY, C_LAST};
   localparam logic [3:0]  VE [NV] = '{4'b1000, 4'b1000, 4'b1000, 4'b1100, 4'b1100,
                                       4'b1110, 4'b1110, 4'b1111, 4'b1111};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic conv_req = 1'b0;
   logic adc_clk_en, ref_pwr_en, core_pwr_en, ready, conv_accept, early_req;
   logic [3:0] obs;
   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   assign obs = {adc_clk_en, ref_pwr_en, core_pwr_en, ready};

   adc_pwrup_seq #(
      .CLK_FREQ_HZ     (1_234_567),
      .REF_WAIT_US     (8000),
      .CORE_WAIT_US    (20),
      .CLK_LEAD_CYCLES (T_LEAD),
      .ACCEPT_REG      (1'b1)
   ) dut (
      .clk         (clk),
      .rst         (rst),
      .start       (start),
      .conv_req    (conv_req),
      .adc_clk_en  (adc_clk_en),
      .ref_pwr_en  (ref_pwr_en),
      .core_pwr_en (core_pwr_en),
      .ready       (ready),
      .conv_accept (conv_accept),
      .early_req   (early_req)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic power_run(input bit hold_start, input bit extras);
      start = 1'b1;
      for (int c = 1; c <= int'(C_LAST); c++) begin
         @(negedge clk);
         if (!hold_start && c == 1) start = 1'b0;
         for (int i = 0; i < NV; i++)
            if (c == int'(VC[i])) check("R2 R3 R4 R5 sequence", 32'(obs), 32'(VE[i]));
         if (extras) begin
            if (c == 60) conv_req = 1'b1;
            if (c == 61) begin
               check("R7 early flag set", 32'(early_req), 32'd1);
               check("R7 early not accepted", 32'(conv_accept), 32'd0);
               conv_req = 1'b0;
            end
            if (c == 200) start = 1'b1;   // R6: ignored in mid sequence
            if (c == 201) start = 1'b0;
            if (c == int'(C_LAST)) check("R7 early sticky", 32'(early_req), 32'd1);
         end
      end
      start = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset outputs", 32'({obs, conv_accept, early_req}), 32'd0);
      rst = 1'b0;
      repeat (6) @(negedge clk);
      check("R2 idle without start", 32'(obs), 32'd0);

      power_run(1'b0, 1'b1);

      // R8: request while ready, held two cycles
      conv_req = 1'b1;
      @(negedge clk);
      check("R8 accept next cycle", 32'(conv_accept), 32'd1);
      check("R8 early unchanged", 32'(early_req), 32'd1);
      @(negedge clk);
      check("R8 accept while held", 32'(conv_accept), 32'd1);
      conv_req = 1'b0;
      @(negedge clk);
      check("R8 accept drops", 32'(conv_accept), 32'd0);

      // R6: start while ready
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      check("R6 ready holds", 32'(obs), 32'hF);

      // R1: reset from ready
      rst = 1'b1;
      @(negedge clk);
      check("R1 reset from ready", 32'({obs, conv_accept, early_req}), 32'd0);
      rst = 1'b0;

      // Second run with start held throughout
      power_run(1'b1, 1'b0);
      check("R7 cleared by reset", 32'(early_req), 32'd0);

      // R1: reset during the reference wait
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (500) @(negedge clk);
      check("R3 in reference wait", 32'(obs), 32'hC);
      rst = 1'b1;
      @(negedge clk);
      check("R1 reset mid sequence", 32'({obs, conv_accept, early_req}), 32'd0);
      rst = 1'b0;
      repeat (20) @(negedge clk);
      check("R2 stays idle after reset", 32'(obs), 32'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule